// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each received Ethernet frame, whether it is kept and which one receive channel takes it. A table of 32 entries sits in a two-port store. A host write port loads the entries. A lookup sequencer compares a frame's 48-bit destination address against the entries, one per clock. Each entry either admits frames carrying its address or rejects them. The table result is combined with per-channel unicast enable bits, per-channel hash enable bits and a multicast hash-hit flag that is computed outside the block. The outcome is keep/drop plus a channel number.

A lookup request enters on a valid/ready handshake. `req_ready` is high only while the sequencer is idle. The destination address and the hash-hit flag are captured on the handshake edge. The result leaves on a valid/ready handshake. Once `res_valid` is raised, it and the result fields hold until `res_ready` is seen high at a clock edge, and no new request is taken before then. If `res_ready` is held high, `res_valid` is a one-cycle pulse. The configuration pins (`uc_en`, `hash_en`, `dflt_chan`) are plain levels. The decision reads them at the end of the scan.

Top module: `rx_addr_filter`

## Requirements
- R1: After synchronous reset no entry is valid, `req_ready` is 1 and `res_valid` is 0. A frame sent before any write matches nothing and is dropped unless the hash path of R7 admits it.
- R2: An entry word has bit 52 = action (1 admit, 0 reject), bit 51 = valid, bits 50:48 = channel and bits 47:0 = the address compared with `req_dst`. An entry with valid 0 never matches. A write applies to every lookup that starts after it.
- R3: When the first matching entry admits and `uc_en[channel]` is 1, the frame is kept on that entry's channel. Every dropped frame reports `res_chan` = 0.
- R4: When the first matching entry rejects, the frame is dropped, even when `req_hash_hit` is 1 and the hash enable of `dflt_chan` is set.
- R5: When the first matching entry admits but `uc_en[channel]` is 0, the frame is dropped. This holds for multicast addresses too: `hash_en` and `req_hash_hit` have no effect on a frame that matched an entry.
- R6: When several valid entries match, the one with the lowest index alone sets the outcome and the channel. Index 0 and index 31 both take part in the scan.
- R7: When no entry matches, a multicast frame (`req_dst` bit 40 = 1) with `req_hash_hit` = 1 and `hash_en[dflt_chan]` = 1 is kept on `dflt_chan`. Every other unmatched frame is dropped. For a unicast frame `req_hash_hit` is ignored.
- R8: `res_valid` rises exactly 33 clock edges (table depth plus one) after the request handshake edge. After a handshake `req_ready` is 0 until the result has been taken.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_valid`, `res_accept` and `res_chan` hold their values.
- R10: Entry k is read at the (k+1)th edge after the handshake. A write to entry k at that same edge does not change the frame in flight. It applies from the next frame on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 5 | Index of the entry written |
| wr_data | input | 53 | Entry word, layout per R2 |
| uc_en | input | 8 | Unicast enable per channel |
| hash_en | input | 8 | Hash enable per channel |
| dflt_chan | input | 3 | Channel for hash-admitted frames |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Sequencer idle, request accepted |
| req_dst | input | 48 | Destination address of the frame |
| req_hash_hit | input | 1 | External multicast hash hit |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result taken |
| res_accept | output | 1 | 1 keep, 0 drop |
| res_chan | output | 3 | Channel of a kept frame, 0 on drop |

## Verification
The assertions assume three things about the inputs:
- `uc_en`, `hash_en` and `dflt_chan` do not change while a lookup is in flight, so a kept result always refers to an enabled channel.
- `wr_idx` stays below the table depth.
- Reset is held for at least one edge at the start.

The stimulus changes configuration only after the previous result has been taken and the sequencer is idle. It writes only indices 0 to 31. It places the single mid-scan write on the exact edge where its entry is read. The result side is exercised both with `res_ready` held high and with a pattern that drops `res_ready` three cycles out of four.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int MAC_W  = 48;
  localparam int CH_N   = 8;
  localparam int CH_W   = $clog2(CH_N);
  localparam int ENT_W  = MAC_W + CH_W + 2;
  localparam int MC_BIT = 40;

  typedef struct packed {
    logic            keep;
    logic            vld;
    logic [CH_W-1:0] chan;
    logic [MAC_W-1:0] mac;
  } ent_t;
endpackage

// File: rtl/rxf_table.sv
module rxf_table
  import rxf_pkg::*;
#(
  parameter int N_ENT = 32,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  ent_t             wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ent_t             rd_ent
);
  localparam int WORD_W = ENT_W - 1;

  logic [WORD_W-1:0] store [N_ENT];
  logic [N_ENT-1:0]  vld_q;
  logic [WORD_W-1:0] rd_word;
  logic              rd_vld;

  // valid flags live in flops so reset can clear them
  for (genvar i = 0; i < N_ENT; i++) begin : g_vld
    always_ff @(posedge clk) begin
      if (rst) vld_q[i] <= 1'b0;
      else if (wr_en && wr_idx == IDX_W'(i)) vld_q[i] <= wr_data.vld;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= {wr_data.keep, wr_data.chan, wr_data.mac};
  end

  // read returns the word as it was before a same-edge write
  always_ff @(posedge clk) begin
    if (rd_en) rd_word <= store[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else if (rd_en) rd_vld <= vld_q[rd_idx];
  end

  always_comb begin
    rd_ent.keep = rd_word[WORD_W-1];
    rd_ent.vld  = rd_vld;
    rd_ent.chan = rd_word[MAC_W +: CH_W];
    rd_ent.mac  = rd_word[MAC_W-1:0];
  end

  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_idx)] == $past(wr_data.vld));
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
(
  input  logic            hit_any,
  input  logic            hit_keep,
  input  logic [CH_W-1:0] hit_chan,
  input  logic            dst_mc,
  input  logic            hash_hit,
  input  logic [CH_N-1:0] uc_en,
  input  logic [CH_N-1:0] hash_en,
  input  logic [CH_W-1:0] dflt_chan,
  output logic            accept,
  output logic [CH_W-1:0] chan
);
  always_comb begin
    accept = 1'b0;
    chan   = '0;
    if (hit_any) begin
      if (hit_keep && uc_en[hit_chan]) begin
        accept = 1'b1;
        chan   = hit_chan;
      end
    end else if (dst_mc && hash_hit && hash_en[dflt_chan]) begin
      accept = 1'b1;
      chan   = dflt_chan;
    end
  end
endmodule

// File: rtl/rxf_scan.sv
module rxf_scan
  import rxf_pkg::*;
#(
  parameter int N_ENT = 32,
  localparam int IDX_W = $clog2(N_ENT),
  localparam int LAT   = N_ENT + 1,
  localparam int LAT_W = $clog2(N_ENT + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [MAC_W-1:0] req_dst,
  input  logic             req_hash_hit,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_accept,
  output logic [CH_W-1:0]  res_chan,
  output logic             rd_en,
  output logic [IDX_W-1:0] rd_idx,
  input  ent_t             rd_ent,
  output logic             hit_any,
  output logic             hit_keep,
  output logic [CH_W-1:0]  hit_chan,
  output logic             dst_mc,
  output logic             hash_q,
  input  logic             dec_accept,
  input  logic [CH_W-1:0]  dec_chan
);
  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_LAST, S_HOLD} st_t;

  st_t              state;
  logic [IDX_W-1:0] idx_q;
  logic [MAC_W-1:0] dst_q;
  logic             cmp_vld_q;
  logic             found_q;
  logic             keep_q;
  logic [CH_W-1:0]  chan_q;
  logic [LAT_W-1:0] lat_q;
  logic             cmp_hit;
  logic             take;

  assign req_ready = (state == S_IDLE);
  assign rd_en     = (state == S_SCAN);
  assign rd_idx    = idx_q;
  assign dst_mc    = dst_q[MC_BIT];

  // first valid match in index order wins
  assign cmp_hit  = cmp_vld_q && rd_ent.vld && (rd_ent.mac == dst_q);
  assign take     = cmp_hit && !found_q;
  assign hit_any  = found_q || take;
  assign hit_keep = take ? rd_ent.keep : keep_q;
  assign hit_chan = take ? rd_ent.chan : chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      idx_q      <= '0;
      dst_q      <= '0;
      hash_q     <= 1'b0;
      cmp_vld_q  <= 1'b0;
      found_q    <= 1'b0;
      keep_q     <= 1'b0;
      chan_q     <= '0;
      lat_q      <= '0;
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_chan   <= '0;
    end else begin
      cmp_vld_q <= (state == S_SCAN);
      unique case (state)
        S_IDLE: begin
          if (req_valid) begin
            dst_q   <= req_dst;
            hash_q  <= req_hash_hit;
            idx_q   <= '0;
            found_q <= 1'b0;
            keep_q  <= 1'b0;
            chan_q  <= '0;
            lat_q   <= '0;
            state   <= S_SCAN;
          end
        end
        S_SCAN: begin
          idx_q   <= idx_q + 1'b1;
          lat_q   <= lat_q + 1'b1;
          found_q <= hit_any;
          keep_q  <= hit_keep;
          chan_q  <= hit_chan;
          if (idx_q == IDX_W'(N_ENT - 1)) state <= S_LAST;
        end
        S_LAST: begin
          lat_q      <= lat_q + 1'b1;
          res_valid  <= 1'b1;
          res_accept <= dec_accept;
          res_chan   <= dec_chan;
          state      <= S_HOLD;
        end
        S_HOLD: begin
          if (res_ready) begin
            res_valid <= 1'b0;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_after_rst_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && !res_valid));

  // R8
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (!req_ready && !res_valid));

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> (lat_q == LAT_W'(LAT)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_accept) && $stable(res_chan)));

  // R3
  drop_chan_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_accept) |-> (res_chan == '0));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int N_ENT = 32,
  localparam int IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [ENT_W-1:0] wr_data,
  input  logic [CH_N-1:0]  uc_en,
  input  logic [CH_N-1:0]  hash_en,
  input  logic [CH_W-1:0]  dflt_chan,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [MAC_W-1:0] req_dst,
  input  logic             req_hash_hit,
  output logic             res_valid,
  input  logic             res_ready,
  output logic             res_accept,
  output logic [CH_W-1:0]  res_chan
);
  ent_t             wr_ent;
  ent_t             rd_ent;
  logic             rd_en;
  logic [IDX_W-1:0] rd_idx;
  logic             hit_any;
  logic             hit_keep;
  logic [CH_W-1:0]  hit_chan;
  logic             dst_mc;
  logic             hash_q;
  logic             dec_accept;
  logic [CH_W-1:0]  dec_chan;

  assign wr_ent = ent_t'(wr_data);

  rxf_table #(.N_ENT(N_ENT)) u_table (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_ent),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_ent  (rd_ent)
  );

  rxf_scan #(.N_ENT(N_ENT)) u_scan (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_dst      (req_dst),
    .req_hash_hit (req_hash_hit),
    .res_valid    (res_valid),
    .res_ready    (res_ready),
    .res_accept   (res_accept),
    .res_chan     (res_chan),
    .rd_en        (rd_en),
    .rd_idx       (rd_idx),
    .rd_ent       (rd_ent),
    .hit_any      (hit_any),
    .hit_keep     (hit_keep),
    .hit_chan     (hit_chan),
    .dst_mc       (dst_mc),
    .hash_q       (hash_q),
    .dec_accept   (dec_accept),
    .dec_chan     (dec_chan)
  );

  rxf_decide u_decide (
    .hit_any   (hit_any),
    .hit_keep  (hit_keep),
    .hit_chan  (hit_chan),
    .dst_mc    (dst_mc),
    .hash_hit  (hash_q),
    .uc_en     (uc_en),
    .hash_en   (hash_en),
    .dflt_chan (dflt_chan),
    .accept    (dec_accept),
    .chan      (dec_chan)
  );
endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [52:0] wr_data = '0;
  logic [7:0]  uc_en = '0;
  logic [7:0]  hash_en = '0;
  logic [2:0]  dflt_chan = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_dst = '0;
  logic        req_hash_hit = 1'b0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic        res_accept;
  logic [2:0]  res_chan;

  rx_addr_filter u0 (.*);

  always #(CLK_PER/2) clk = ~clk;

  int errs = 0;
  int checks = 0;
  int cyc = 0;
  bit bp = 1'b0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  string      tag_q[$];
  int         hs_q[$];

  logic [47:0] m_mac [32];
  logic [2:0]  m_ch  [32];
  bit          m_v   [32];
  bit          m_k   [32];

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [3:0] predict(logic [47:0] dst, bit hh);
    for (int i = 0; i < 32; i++)
      if (m_v[i] && m_mac[i] == dst)
        return (m_k[i] && uc_en[m_ch[i]]) ? {1'b1, m_ch[i]} : 4'b0;
    if (dst[40] && hh && hash_en[dflt_chan]) return {1'b1, dflt_chan};
    return 4'b0;
  endfunction

  task automatic put(int idx, logic [47:0] mac, logic [2:0] ch, bit v, bit k);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'(idx); wr_data = {k, v, ch, mac};
    @(negedge clk);
    wr_en = 1'b0;
    m_mac[idx] = mac; m_ch[idx] = ch; m_v[idx] = v; m_k[idx] = k;
  endtask

  task automatic issue(logic [47:0] dst, bit hh, string tag);
    exp_q.push_back(predict(dst, hh));
    tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_dst = dst; req_hash_hit = hh;
    @(negedge clk);
    req_valid = 1'b0;
    hs_q.push_back(cyc);
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send(logic [47:0] dst, bit hh, string tag);
    issue(dst, hh, tag);
    wait_done();
  endtask

  initial forever begin
    @(posedge clk);
    cyc <= cyc + 1;
    res_ready <= bp ? (cyc[1:0] == 2'd0) : 1'b1;
  end

  // monitor / scoreboard
  bit prev_rv = 1'b0;
  bit hold_pend = 1'b0;
  logic h_acc;
  logic [2:0] h_ch;
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (res_valid && !prev_rv) begin
        if (hs_q.size() != 0) begin
          automatic int c0 = hs_q.pop_front();
          // R8 result rises 33 edges after the handshake
          chk(cyc - c0 == 33, "R8", "latency", cyc - c0, 33);
        end else chk(1'b0, "R8", "unexpected result", 1, 0);
      end
      if (hold_pend)
        // R9 stalled result is held
        chk(res_valid && res_accept == h_acc && res_chan == h_ch, "R9", "hold",
            {res_valid, res_accept, res_chan}, {1'b1, h_acc, h_ch});
      hold_pend = res_valid && !res_ready;
      h_acc = res_accept; h_ch = res_chan;
      if (res_valid && res_ready) begin
        if (exp_q.size() != 0) begin
          automatic logic [3:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk({res_accept, res_chan} == e, t, "decision", {res_accept, res_chan}, e);
        end else chk(1'b0, "R8", "result without request", 1, 0);
      end
      prev_rv = res_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", "timeout", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  localparam logic [47:0] UA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] UB = 48'h02_AA_BB_CC_DD_EE;
  localparam logic [47:0] M1 = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] M2 = 48'h01_00_5E_00_00_02;
  localparam logic [47:0] M3 = 48'h01_00_5E_00_00_03;
  localparam logic [47:0] DD = 48'h02_00_00_00_0D_0D;
  localparam logic [47:0] EA = 48'h02_00_00_00_0E_0A;

  initial begin
    for (int i = 0; i < 32; i++) begin
      m_mac[i] = '0; m_ch[i] = '0; m_v[i] = 1'b0; m_k[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    chk(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
    uc_en = 8'hFF; hash_en = 8'h00; dflt_chan = 3'd6;
    send(UA, 1'b0, "R1");
    send(M1, 1'b1, "R1");

    put(3, UA, 3'd2, 1'b1, 1'b1);
    send(UA, 1'b0, "R3");
    send(UB, 1'b0, "R3");
    uc_en = 8'hFB;
    send(UA, 1'b0, "R5");

    uc_en = 8'hFF;
    put(7, M1, 3'd5, 1'b1, 1'b1);
    send(M1, 1'b0, "R3");
    uc_en = 8'hDF; hash_en = 8'hFF;
    send(M1, 1'b1, "R5");

    uc_en = 8'hFF; hash_en = 8'h40;
    put(9, M2, 3'd1, 1'b1, 1'b0);
    send(M2, 1'b1, "R4");
    send(M3, 1'b1, "R7");
    send(M3, 1'b0, "R7");
    send(UB, 1'b1, "R7");
    hash_en = 8'hBF;
    send(M3, 1'b1, "R7");

    put(12, DD, 3'd3, 1'b1, 1'b0);
    put(20, DD, 3'd4, 1'b1, 1'b1);
    send(DD, 1'b0, "R6");
    put(0, DD, 3'd1, 1'b1, 1'b1);
    send(DD, 1'b0, "R6");
    put(31, EA, 3'd7, 1'b1, 1'b1);
    send(EA, 1'b0, "R6");

    put(3, UA, 3'd2, 1'b0, 1'b1);
    send(UA, 1'b0, "R2");
    put(3, UA, 3'd2, 1'b1, 1'b1);
    send(UA, 1'b0, "R2");

    // R10 write entry 5 on the edge that reads it
    put(5, UB, 3'd3, 1'b1, 1'b1);
    issue(UB, 1'b0, "R10");
    repeat (5) @(negedge clk);
    wr_en = 1'b1; wr_idx = 5'd5; wr_data = {1'b0, 1'b1, 3'd3, UB};
    @(negedge clk);
    wr_en = 1'b0;
    m_k[5] = 1'b0;
    wait_done();
    send(UB, 1'b0, "R10");

    bp = 1'b1;
    hash_en = 8'hFF;
    send(UA, 1'b0, "R9");
    send(M3, 1'b1, "R9");
    send(DD, 1'b0, "R9");
    send(UB, 1'b0, "R9");
    bp = 1'b0;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule